// File: doc/BRIEF.md
# Two-Phase Separable Switch Allocator

This block decides, every cycle, which router input may drive which router output through the crossbar. It takes a request matrix with one row per input (requester) and one column per output (resource) and returns a grant matrix of the same shape that forms a valid matching: each input wins at most one output, each output serves at most one input, and every grant sits on a request. The result is combinational, so grants appear in the same cycle as the requests that cause them.

The matching is built in two phases of small round-robin arbiters. One bank holds one arbiter per input row and the other holds one arbiter per output column. The arbiters in a bank never talk to each other. A parameter sets the order of the phases. In input-first order, each row arbiter picks one of its requested outputs, and then each column arbiter picks one of the inputs that chose it. In output-first order, the column bank runs first on the raw requests and the row bank then picks one of the offers it received. Each arbiter keeps a registered priority pointer that moves past its winner only when that arbiter's choice becomes a final grant.

Each arbiter has two named conditions per cycle. In HOLD, no final grant passes through it and the pointer stays where it is. In ADVANCE, a final grant passes through it and the pointer moves to the index after the winner, wrapping from the last index to 0. Reset puts every pointer at index 0.

Top module: `sep_switch_alloc`

## Requirements
- R1: A grant bit `gnt_mat[i*N_RES+j]` (input i, output j) is set only when the matching request bit `req_mat[i*N_RES+j]` is set.
- R2: No grant row (fixed input i, all outputs j) has more than one bit set.
- R3: No grant column (fixed output j, all inputs i) has more than one bit set.
- R4: When the request matrix is not all zero, at least one grant is issued in the same cycle. An all-zero request matrix yields an all-zero grant matrix.
- R5: A request matrix with exactly one bit set is granted on that same bit in the same cycle, in either phase order.
- R6: With N_REQ equal to N_RES and every request bit held at 1 from reset, the grant matrix is a full permutation (one bit in every row and in every column) from the N_REQ-th cycle onward, in either phase order.
- R7: Two inputs that hold requests for the same single output receive it in alternating cycles. Neither is starved.
- R8: An arbiter's pointer moves only when its choice becomes a final grant. An input whose first-phase choice loses keeps its priority for the next cycle.
- R9: After reset all pointers are at index 0, so the lowest index wins first. ORDER selects the phase order: with input 0 requesting output 0 and input 1 requesting outputs 0 and 1, the first cycle grants only (0,0) in input-first order, and grants (0,0) and (1,1) in output-first order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the priority pointers |
| rst_n | input | 1 | Asynchronous active-low reset, sets all pointers to 0 |
| req_mat | input | N_REQ*N_RES | Request matrix, bit i*N_RES+j means input i wants output j |
| gnt_mat | output | N_REQ*N_RES | Grant matrix, same layout as req_mat |

## Verification
The assertions check the matching rules on every cycle: grants are a subset of requests, every row and every column has at most one grant, some grant is issued whenever there is a request, and each arbiter's pointer holds still when no final grant passes through it. Other properties only show up over a sequence of cycles, so only the bench scenarios can demonstrate them. These are the convergence of a full request matrix to a permutation, the alternation between two contenders for one output, the exact grants that distinguish the two phase orders after reset, and the retained priority of a losing input.

// File: rtl/sa_pkg.sv
package sa_pkg;

    typedef enum logic {
        ORDER_INPUT_FIRST  = 1'b0,
        ORDER_OUTPUT_FIRST = 1'b1
    } alloc_order_e;

endpackage

// File: rtl/sa_rr_arb.sv
module sa_rr_arb #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] req,
    input  logic             adv,
    output logic [WIDTH-1:0] gnt
);

    localparam int PW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(WIDTH - 1);

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] win;
    logic          found;

    // pick the first requester at or after the pointer, wrapping around
    always_comb begin
        gnt   = '0;
        found = 1'b0;
        win   = '0;
        for (int k = 0; k < WIDTH; k++) begin
            int idx;
            idx = (int'(ptr_q) + k) % WIDTH;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
                win      = PW'(idx);
            end
        end
    end

    // HOLD when no final grant passes through, ADVANCE past the winner otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv && found) begin
            ptr_q <= (win == LAST) ? '0 : win + PW'(1);
        end
    end

    assert_arb_onehot_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_arb_subset_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);

    assert_arb_nonempty_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> (gnt != '0));

    assert_ptr_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr_q));

endmodule

// File: rtl/sa_arb_bank.sv
module sa_arb_bank #(
    parameter int NUM   = 4,
    parameter int WIDTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM*WIDTH-1:0] req,
    input  logic [NUM-1:0]       adv,
    output logic [NUM*WIDTH-1:0] gnt
);

    for (genvar a = 0; a < NUM; a++) begin : g_arb
        sa_rr_arb #(
            .WIDTH(WIDTH)
        ) arb_i (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (req[a*WIDTH +: WIDTH]),
            .adv  (adv[a]),
            .gnt  (gnt[a*WIDTH +: WIDTH])
        );
    end

endmodule

// File: rtl/sep_switch_alloc.sv
module sep_switch_alloc
    import sa_pkg::*;
#(
    parameter int           N_REQ = 4,
    parameter int           N_RES = 4,
    parameter alloc_order_e ORDER = ORDER_INPUT_FIRST
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_REQ*N_RES-1:0] req_mat,
    output logic [N_REQ*N_RES-1:0] gnt_mat
);

    localparam int NBITS = N_REQ * N_RES;

    // row bank: index i*N_RES+j ; column bank: index j*N_REQ+i
    logic [NBITS-1:0] row_req, row_gnt;
    logic [NBITS-1:0] col_req, col_gnt;
    logic [N_REQ-1:0] row_adv;
    logic [N_RES-1:0] col_adv;

    sa_arb_bank #(
        .NUM  (N_REQ),
        .WIDTH(N_RES)
    ) row_bank_i (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (row_req),
        .adv  (row_adv),
        .gnt  (row_gnt)
    );

    sa_arb_bank #(
        .NUM  (N_RES),
        .WIDTH(N_REQ)
    ) col_bank_i (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (col_req),
        .adv  (col_adv),
        .gnt  (col_gnt)
    );

    if (ORDER == ORDER_INPUT_FIRST) begin : g_in_first
        always_comb begin
            row_req = req_mat;
            for (int i = 0; i < N_REQ; i++) begin
                for (int j = 0; j < N_RES; j++) begin
                    col_req[j*N_REQ+i] = row_gnt[i*N_RES+j];
                    gnt_mat[i*N_RES+j] = col_gnt[j*N_REQ+i];
                end
            end
        end
    end else begin : g_out_first
        always_comb begin
            for (int i = 0; i < N_REQ; i++) begin
                for (int j = 0; j < N_RES; j++) begin
                    col_req[j*N_REQ+i] = req_mat[i*N_RES+j];
                    row_req[i*N_RES+j] = col_gnt[j*N_REQ+i];
                end
            end
            gnt_mat = row_gnt;
        end
    end

    // an arbiter advances only when a final grant passes through it
    always_comb begin
        row_adv = '0;
        col_adv = '0;
        for (int i = 0; i < N_REQ; i++) begin
            for (int j = 0; j < N_RES; j++) begin
                if (gnt_mat[i*N_RES+j]) begin
                    row_adv[i] = 1'b1;
                    col_adv[j] = 1'b1;
                end
            end
        end
    end

    assert_grant_in_req_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_mat & ~req_mat) == '0);

    assert_progress_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (req_mat != '0) |-> (gnt_mat != '0));

    for (genvar r = 0; r < N_REQ; r++) begin : g_row_chk
        assert_row_onehot_R2 : assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt_mat[r*N_RES +: N_RES]));
    end

    for (genvar c = 0; c < N_RES; c++) begin : g_col_chk
        logic [N_REQ-1:0] col_bits;
        always_comb begin
            for (int i = 0; i < N_REQ; i++) col_bits[i] = gnt_mat[i*N_RES+c];
        end
        assert_col_onehot_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col_bits));
    end

endmodule

// File: tb/sep_switch_alloc_tb_top.sv
module sep_switch_alloc_tb_top;
    import sa_pkg::*;

    localparam int NQ = 4;
    localparam int NS = 4;
    localparam int NB = NQ * NS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] req = '0;
    logic [NB-1:0] g_if, g_of;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    sep_switch_alloc #(.N_REQ(NQ), .N_RES(NS), .ORDER(ORDER_INPUT_FIRST)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_mat(req), .gnt_mat(g_if));

    sep_switch_alloc #(.N_REQ(NQ), .N_RES(NS), .ORDER(ORDER_OUTPUT_FIRST)) dut_of_i (
        .clk(clk), .rst_n(rst_n), .req_mat(req), .gnt_mat(g_of));

    task automatic chk(input bit ok, input string tag, input logic [NB-1:0] act,
                       input logic [NB-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit rows_ok(input logic [NB-1:0] g);
        for (int i = 0; i < NQ; i++) begin
            int cnt = 0;
            for (int j = 0; j < NS; j++) cnt += int'(g[i*NS+j]);
            if (cnt > 1) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit cols_ok(input logic [NB-1:0] g);
        for (int j = 0; j < NS; j++) begin
            int cnt = 0;
            for (int i = 0; i < NQ; i++) cnt += int'(g[i*NS+j]);
            if (cnt > 1) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit is_perm(input logic [NB-1:0] g);
        for (int i = 0; i < NQ; i++) begin
            int rc = 0;
            int cc = 0;
            for (int j = 0; j < NS; j++) begin
                rc += int'(g[i*NS+j]);
                cc += int'(g[j*NS+i]);
            end
            if (rc != 1 || cc != 1) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req   = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drive(input logic [NB-1:0] v);
        @(negedge clk);
        req = v;
        #1;
    endtask

    task automatic check_matching(input logic [NB-1:0] g, input string who);
        chk((g & ~req) == '0, {"R1 subset ", who}, g, g & req);
        chk(rows_ok(g), {"R2 row ", who}, g, req);
        chk(cols_ok(g), {"R3 col ", who}, g, req);
        chk((req == '0) ? (g == '0) : (g != '0), {"R4 progress ", who}, g, req);
    endtask

    initial begin
        void'($urandom(32'h5eed_a11c));
        do_reset();

        // reset state: no request gives no grant (R4)
        drive('0);
        chk(g_if == '0, "R4 reset idle IF", g_if, '0);
        chk(g_of == '0, "R4 reset idle OF", g_of, '0);

        // R9: phase order and pointer start at 0
        do_reset();
        drive(16'h0031);
        chk(g_if == 16'h0001, "R9 input-first", g_if, 16'h0001);
        chk(g_of == 16'h0021, "R9 output-first", g_of, 16'h0021);
        // R8: input 1 lost in input-first order, keeps its pointer on output 0
        drive(16'h0031);
        chk(g_if == 16'h0010, "R8 loser keeps priority", g_if, 16'h0010);

        // R5: lone request granted on the same bit
        do_reset();
        for (int b = 0; b < NB; b++) begin
            logic [NB-1:0] one;
            one = '0;
            one[b] = 1'b1;
            drive(one);
            chk(g_if == one, "R5 lone IF", g_if, one);
            chk(g_of == one, "R5 lone OF", g_of, one);
        end

        // R7: inputs 1 and 3 share output 2 (bits 6 and 14)
        do_reset();
        for (int c = 0; c < 6; c++) begin
            logic [NB-1:0] e;
            e = (c % 2 == 0) ? 16'h0040 : 16'h4000;
            drive(16'h4040);
            chk(g_if == e, "R7 alternate IF", g_if, e);
            chk(g_of == e, "R7 alternate OF", g_of, e);
        end

        // R6: full request matrix converges to a permutation by cycle NQ
        do_reset();
        for (int c = 1; c <= 2 * NQ; c++) begin
            drive('1);
            check_matching(g_if, "IF");
            check_matching(g_of, "OF");
            if (c >= NQ) begin
                chk(is_perm(g_if), "R6 permutation IF", g_if, '1);
                chk(is_perm(g_of), "R6 permutation OF", g_of, '1);
            end
        end

        // constrained random: sparse, dense and full patterns
        do_reset();
        for (int c = 0; c < 600; c++) begin
            logic [NB-1:0] v;
            case (c % 3)
                0: v = NB'($urandom & $urandom);
                1: v = NB'($urandom | $urandom);
                default: v = NB'($urandom);
            endcase
            if (c % 50 == 7) v = '1;
            drive(v);
            check_matching(g_if, "IF");
            check_matching(g_of, "OF");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

endmodule